// File: doc/BRIEF.md
# Banked System-Handler Priority Registers

This block stores the 8-bit priorities of the configurable system exception handlers of an interrupt controller that has a secure and a non-secure security state. A bus slave reaches them through a 12-byte window at byte offsets 0xD18 to 0xD23. Each byte of the window is one handler. The handler number of a byte is its offset minus 0xD14, so the window covers handlers 4 to 15. One access moves 1, 2 or 4 bytes, and every access carries a secure attribute.

Each byte lane of an access is routed on its own. A lane reaches the non-secure copy of a handler, reaches its secure copy, or is suppressed. A suppressed lane reads as zero and drops its write data. The route depends on three things: the handler number, the secure attribute, and an input that lets the non-secure side reach the bus-fault priority.

The block drives both banks continuously to a downstream priority resolver. After every write it pulses a one-cycle strobe so that the resolver can recompute. Read data is registered and arrives one cycle after the request.

Top module: `shp_bank_regs`

## Requirements
- R1: After reset, every priority byte in both exported banks is 0, and `rd_valid` and `upd_stb` are 0.
- R2: A read request (`req_valid`=1, `req_write`=0) gives `rd_valid`=1 in the next cycle, with the read word on `rdata`. In any cycle that follows a cycle with no read request, `rd_valid` is 0.
- R3: `req_size` sets the number of lanes: 0 is one byte, 1 is two bytes, 2 is four bytes, and 3 is no lanes. Lane i carries data bits [8i+7:8i] and handler (`req_addr`-0xD14)+i. Each of the following lanes is left untouched and reads as zero:
  - a lane past offset 0xD23;
  - a lane beyond the access size;
  - any lane of an access whose start address is outside 0xD18..0xD23.
- R4: Handlers 4 (memory management), 6 (usage fault), 11 (supervisor call), 14 (deferred service call) and 15 (system tick) are banked. A secure access reads or writes the secure copy, and a non-secure access reads or writes the non-secure copy.
- R5: Handler 5 (bus fault) has a single copy. Secure accesses always reach it. Non-secure accesses reach it only when `bf_ns_en`=1; otherwise they read zero and the write is ignored.
- R6: Handler 7 (secure fault) has a single copy. Only secure accesses reach it. Non-secure accesses read zero and their writes are ignored.
- R7: Handler 12 (debug monitor) has a single copy, and accesses from both security states reach it.
- R8: Handlers 8, 9, 10 and 13 are reserved. They read as zero and ignore writes from both security states.
- R9: `upd_stb` is high for exactly the one cycle after each write request, whether or not any lane was written.
- R10: `prio_ns` and `prio_s` carry handler k+4 in bits [8k+7:8k]. A write becomes visible there in the cycle after the request. Slots of handlers without a secure copy always read 0 in `prio_s`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the access |
| req_addr | input | 12 | Byte offset of the first lane |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: none |
| req_wdata | input | 32 | Write data, byte lanes by position |
| bf_ns_en | input | 1 | Non-secure access to bus-fault priority allowed |
| rd_valid | output | 1 | Read data valid |
| rdata | output | 32 | Read data |
| upd_stb | output | 1 | One-cycle pulse after a write |
| prio_ns | output | 96 | Non-secure bank, handlers 4..15 |
| prio_s | output | 96 | Secure bank, handlers 4..15 |

## Verification
Two functions can meet in one access: lanes with different routes and the update of the exported banks. A single 4-byte access can write one handler, hit the secure copy of another, and drop a third that is reserved or denied. The random mix of addresses, sizes, security attributes and `bf_ns_en` values keeps producing such accesses. Each one is judged lane by lane against a bench model of both banks, through both `rdata` and the two exported banks.

A write followed at once by a read of the same byte tests that the new value reaches the read path and the export in the same cycle.

// File: rtl/shp_pkg.sv
package shp_pkg;

    typedef enum logic [1:0] {
        RT_NONE = 2'd0,
        RT_NS   = 2'd1,
        RT_SEC  = 2'd2
    } route_e;

    localparam int HDL_MEM   = 4;
    localparam int HDL_BUS   = 5;
    localparam int HDL_USAGE = 6;
    localparam int HDL_SFLT  = 7;
    localparam int HDL_SVC   = 11;
    localparam int HDL_DBG   = 12;
    localparam int HDL_PSV   = 14;
    localparam int HDL_TICK  = 15;

    function automatic route_e shp_route(input int hidx, input logic sec, input logic bf_en);
        route_e r;
        case (hidx)
            HDL_MEM, HDL_USAGE, HDL_SVC, HDL_PSV, HDL_TICK:
                r = sec ? RT_SEC : RT_NS;
            HDL_BUS:
                r = (sec || bf_en) ? RT_NS : RT_NONE;
            HDL_SFLT:
                r = sec ? RT_NS : RT_NONE;
            HDL_DBG:
                r = RT_NS;
            default:
                r = RT_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/shp_lane_route.sv
module shp_lane_route
    import shp_pkg::*;
#(
    parameter int LANE     = 0,
    parameter int AW       = 12,
    parameter int WIN_LO   = 'hD18,
    parameter int SLOTS    = 12,
    parameter int BASE_HDL = 4
) (
    input  logic [AW-1:0]             addr,
    input  logic [1:0]                size,
    input  logic                      secure,
    input  logic                      bf_en,
    output route_e                    route,
    output logic [$clog2(SLOTS)-1:0]  slot
);
    localparam int WIN_HI = WIN_LO + SLOTS - 1;

    int  pos;
    int  nbytes;
    logic active;

    always_comb begin
        case (size)
            2'd0:    nbytes = 1;
            2'd1:    nbytes = 2;
            2'd2:    nbytes = 4;
            default: nbytes = 0;
        endcase
        pos    = int'(addr) - WIN_LO + LANE;
        active = (int'(addr) >= WIN_LO) && (int'(addr) <= WIN_HI)
                 && (LANE < nbytes) && (pos < SLOTS);
        route  = active ? shp_route(pos + BASE_HDL, secure, bf_en) : RT_NONE;
        slot   = active ? pos[$clog2(SLOTS)-1:0] : '0;
    end
endmodule

// File: rtl/shp_rd_pack.sv
module shp_rd_pack
    import shp_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int SLOTS  = 12,
    parameter int PRIO_W = 8
) (
    input  logic [SLOTS-1:0][PRIO_W-1:0]           ns_bank,
    input  logic [SLOTS-1:0][PRIO_W-1:0]           s_bank,
    input  route_e [LANES-1:0]                     routes,
    input  logic [LANES-1:0][$clog2(SLOTS)-1:0]    slots,
    output logic [LANES*PRIO_W-1:0]                word
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            case (routes[i])
                RT_NS:   word[i*PRIO_W +: PRIO_W] = ns_bank[slots[i]];
                RT_SEC:  word[i*PRIO_W +: PRIO_W] = s_bank[slots[i]];
                default: word[i*PRIO_W +: PRIO_W] = '0;
            endcase
        end
    end
endmodule

// File: rtl/shp_bank_regs.sv
module shp_bank_regs
    import shp_pkg::*;
#(
    parameter int AW       = 12,
    parameter int WIN_LO   = 'hD18,
    parameter int SLOTS    = 12,
    parameter int BASE_HDL = 4,
    parameter int PRIO_W   = 8,
    parameter int LANES    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic                    req_secure,
    input  logic [AW-1:0]           req_addr,
    input  logic [1:0]              req_size,
    input  logic [LANES*PRIO_W-1:0] req_wdata,
    input  logic                    bf_ns_en,
    output logic                    rd_valid,
    output logic [LANES*PRIO_W-1:0] rdata,
    output logic                    upd_stb,
    output logic [SLOTS*PRIO_W-1:0] prio_ns,
    output logic [SLOTS*PRIO_W-1:0] prio_s
);
    localparam int SW = $clog2(SLOTS);
    localparam int DW = LANES * PRIO_W;

    typedef struct packed {
        logic [SLOTS-1:0][PRIO_W-1:0] ns;
        logic [SLOTS-1:0][PRIO_W-1:0] sec;
        logic [DW-1:0]                rdata;
        logic                         rvld;
        logic                         upd;
    } state_t;

    state_t st_d, st_q;

    route_e [LANES-1:0]          lane_rt;
    logic   [LANES-1:0][SW-1:0]  lane_slot;
    logic   [DW-1:0]             rd_word;

    for (genvar i = 0; i < LANES; i++) begin : g_route
        shp_lane_route #(
            .LANE(i), .AW(AW), .WIN_LO(WIN_LO), .SLOTS(SLOTS), .BASE_HDL(BASE_HDL)
        ) u_rt (
            .addr   (req_addr),
            .size   (req_size),
            .secure (req_secure),
            .bf_en  (bf_ns_en),
            .route  (lane_rt[i]),
            .slot   (lane_slot[i])
        );
    end

    shp_rd_pack #(.LANES(LANES), .SLOTS(SLOTS), .PRIO_W(PRIO_W)) u_pack (
        .ns_bank (st_q.ns),
        .s_bank  (st_q.sec),
        .routes  (lane_rt),
        .slots   (lane_slot),
        .word    (rd_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.rvld = req_valid && !req_write;
        st_d.upd  = req_valid && req_write;
        if (req_valid && !req_write) begin
            st_d.rdata = rd_word;
        end
        if (req_valid && req_write) begin
            for (int i = 0; i < LANES; i++) begin
                case (lane_rt[i])
                    RT_NS:   st_d.ns[lane_slot[i]]  = req_wdata[i*PRIO_W +: PRIO_W];
                    RT_SEC:  st_d.sec[lane_slot[i]] = req_wdata[i*PRIO_W +: PRIO_W];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.rvld;
    assign rdata    = st_q.rdata;
    assign upd_stb  = st_q.upd;
    assign prio_ns  = st_q.ns;
    assign prio_s   = st_q.sec;
endmodule

// File: rtl/shp_bank_regs_chk.sv
module shp_bank_regs_chk #(
    parameter int AW     = 12,
    parameter int SLOTS  = 12,
    parameter int PRIO_W = 8,
    parameter int LANES  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_write,
    input logic                    req_secure,
    input logic [AW-1:0]           req_addr,
    input logic                    bf_ns_en,
    input logic                    rd_valid,
    input logic [LANES*PRIO_W-1:0] rdata,
    input logic                    upd_stb,
    input logic [SLOTS*PRIO_W-1:0] prio_ns,
    input logic [SLOTS*PRIO_W-1:0] prio_s
);
    localparam int SL_BUS  = 1;
    localparam int SL_SFLT = 3;
    localparam int SL_DBG  = 8;

    // R2
    read_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R2
    no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    // R9
    write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> upd_stb);

    // R9
    no_stray_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> !upd_stb);

    // R3
    out_of_window_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_addr < 12'hD18 || req_addr > 12'hD23)) |=> (rdata == '0));

    // R4
    ns_write_spares_sec_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure) |=> $stable(prio_s));

    // R5
    bus_fault_ns_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure && !bf_ns_en)
        |=> $stable(prio_ns[SL_BUS*PRIO_W +: PRIO_W]));

    // R6
    sec_fault_ns_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !req_secure)
        |=> $stable(prio_ns[SL_SFLT*PRIO_W +: PRIO_W]));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_ns[4*PRIO_W +: 3*PRIO_W] == '0) && (prio_ns[9*PRIO_W +: PRIO_W] == '0)
        && (prio_s[4*PRIO_W +: 3*PRIO_W] == '0) && (prio_s[9*PRIO_W +: PRIO_W] == '0));

    // R10
    unbanked_sec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_s[SL_BUS*PRIO_W +: PRIO_W] == '0) && (prio_s[SL_SFLT*PRIO_W +: PRIO_W] == '0)
        && (prio_s[SL_DBG*PRIO_W +: PRIO_W] == '0));
endmodule

bind shp_bank_regs shp_bank_regs_chk #(
    .AW(AW), .SLOTS(SLOTS), .PRIO_W(PRIO_W), .LANES(LANES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_secure (req_secure),
    .req_addr   (req_addr),
    .bf_ns_en   (bf_ns_en),
    .rd_valid   (rd_valid),
    .rdata      (rdata),
    .upd_stb    (upd_stb),
    .prio_ns    (prio_ns),
    .prio_s     (prio_s)
);

// File: tb/sim_shp_bank_regs.sv
`timescale 1ns/1ps
module sim_shp_bank_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        bf_ns_en = 1'b0;
    logic        rd_valid;
    logic [31:0] rdata;
    logic        upd_stb;
    logic [95:0] prio_ns;
    logic [95:0] prio_s;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [7:0] m_ns [16];
    logic [7:0] m_s  [16];

    always #4 clk = ~clk;

    shp_bank_regs u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_secure(req_secure), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .bf_ns_en(bf_ns_en), .rd_valid(rd_valid),
        .rdata(rdata), .upd_stb(upd_stb), .prio_ns(prio_ns), .prio_s(prio_s)
    );

    // 0 none, 1 non-secure copy, 2 secure copy (R4..R8)
    function automatic int exp_route(int h, bit sec, bit bf);
        if (h == 4 || h == 6 || h == 11 || h == 14 || h == 15) return sec ? 2 : 1;
        if (h == 5) return (sec || bf) ? 1 : 0;
        if (h == 7) return sec ? 1 : 0;
        if (h == 12) return 1;
        return 0;
    endfunction

    function automatic logic [95:0] pack_bank(bit sec);
        logic [95:0] v;
        for (int k = 0; k < 12; k++) v[k*8 +: 8] = sec ? m_s[k+4] : m_ns[k+4];
        return v;
    endfunction

    task automatic check(string req, logic [95:0] act, logic [95:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, check at next negedge (R2, R3, R9, R10)
    task automatic access(bit wr, bit sec, logic [11:0] a, logic [1:0] sz, logic [31:0] d, string req);
        logic [31:0] exp_rd = '0;
        int n;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 0;
        for (int i = 0; i < n; i++) begin
            int h;
            int r;
            h = int'(a) - 'hD14 + i;
            if (a < 12'hD18 || a > 12'hD23 || h > 15) continue;
            r = exp_route(h, sec, bf_ns_en);
            if (wr) begin
                if (r == 1) m_ns[h] = d[i*8 +: 8];
                if (r == 2) m_s[h]  = d[i*8 +: 8];
            end else begin
                if (r == 1) exp_rd[i*8 +: 8] = m_ns[h];
                if (r == 2) exp_rd[i*8 +: 8] = m_s[h];
            end
        end
        req_valid = 1'b1; req_write = wr; req_secure = sec;
        req_addr = a; req_size = sz; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " R9 strobe"}, 96'(upd_stb), 96'(wr));
        check({req, " R2 valid"}, 96'(rd_valid), 96'(!wr));
        if (!wr) check({req, " R3 rdata"}, 96'(rdata), 96'(exp_rd));
        check({req, " R10 prio_ns"}, prio_ns, pack_bank(1'b0));
        check({req, " R10 prio_s"}, prio_s, pack_bank(1'b1));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nvec++; nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        for (int h = 0; h < 16; h++) begin m_ns[h] = '0; m_s[h] = '0; end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 prio_ns", prio_ns, '0);
        check("R1 prio_s", prio_s, '0);
        check("R1 rd_valid", 96'(rd_valid), 96'(0));
        check("R1 upd_stb", 96'(upd_stb), 96'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R4 banked SVC/PendSV/SysTick in both banks
        access(1, 1, 12'hD1F, 2'd0, 32'h0000_00A0, "R4 sec svc");
        access(1, 0, 12'hD1F, 2'd0, 32'h0000_0050, "R4 ns svc");
        access(0, 1, 12'hD1F, 2'd0, 32'h0, "R4 rd sec svc");
        access(0, 0, 12'hD20, 2'd2, 32'h0, "R4 rd ns word");
        // R5 bus fault gated by bf_ns_en
        bf_ns_en = 1'b0;
        access(1, 0, 12'hD19, 2'd0, 32'h0000_0077, "R5 ns denied");
        access(0, 0, 12'hD18, 2'd2, 32'h0, "R5 rd denied");
        bf_ns_en = 1'b1;
        access(1, 0, 12'hD18, 2'd2, 32'h4433_2211, "R5 ns allowed");
        access(0, 1, 12'hD18, 2'd2, 32'h0, "R5 rd sec");
        // R6 secure fault
        access(1, 0, 12'hD1B, 2'd0, 32'h0000_00EE, "R6 ns write");
        access(1, 1, 12'hD1B, 2'd0, 32'h0000_0090, "R6 sec write");
        access(0, 0, 12'hD18, 2'd2, 32'h0, "R6 ns read");
        // R7 debug monitor shared, R8 reserved
        access(1, 0, 12'hD20, 2'd0, 32'h0000_0033, "R7 ns dbg");
        access(0, 1, 12'hD20, 2'd0, 32'h0, "R7 sec dbg");
        access(1, 1, 12'hD1C, 2'd2, 32'hFFFF_FFFF, "R8 reserved word");
        access(1, 0, 12'hD20, 2'd2, 32'hFFFF_FFFF, "R8 reserved 13");
        access(0, 1, 12'hD1C, 2'd2, 32'h0, "R8 read back");
        // R3 edges: unaligned past end, outside window, size 3
        access(1, 0, 12'hD23, 2'd2, 32'h1234_5601, "R3 past end");
        access(1, 1, 12'hD24, 2'd2, 32'hDEAD_BEEF, "R3 outside");
        access(0, 1, 12'hD14, 2'd2, 32'h0, "R3 read outside");
        access(1, 1, 12'hD18, 2'd3, 32'hCAFE_F00D, "R3 size none");
        access(1, 1, 12'hD22, 2'd1, 32'h0000_5AA5, "R3 halfword");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            a = ($urandom % 8 == 0) ? 12'(12'hD10 + $urandom % 24) : 12'(12'hD18 + $urandom % 12);
            bf_ns_en = 1'($urandom);
            access(1'($urandom), 1'($urandom), a, 2'($urandom), $urandom, "R4 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule